// File: doc/BRIEF.md
# Firmware Glue Register Block

A small memory-mapped peripheral that gives boot firmware a few platform services through a simple register bus. A bus access carries an address, 32 bits of write data, a size code (one, two or four bytes), read and write strobes, and the number of the processor making the request. The block answers with the requester's number and the processor count. It lets software raise a halt request that carries an exit code, and lets it drive one level-sensitive interrupt line per processor. It also provides a one-character console path in each direction, each with a status register.

Byte 0 of an access, the first byte addressed, travels on `bus_wdata[7:0]`, and byte 1 travels on `bus_wdata[15:8]`. Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe, with the register's 8-bit value in bits 7:0. In every other cycle `bus_rdata` is zero. The console receiver is a byte valid/ready source. The block samples it only when software reads the receive-status register. The transmitter sees a one-cycle valid pulse each time software writes the transmit-data register.

Only address bits 4:0 are decoded. The offsets are:
- halt: 0x00
- requester number: 0x04
- interrupt control: 0x08
- processor count: 0x0A
- receive data: 0x10
- receive status: 0x14
- transmit data: 0x18
- transmit status: 0x1A

Top module: `fwglue_regs`

## Requirements
- R1: After synchronous reset the block holds these values:
  - transmit status 1 and transmit data 0
  - receive status 0 and receive data 0
  - every interrupt line low
  - `halt_req` low and `tx_valid` low
- R2: Reads are decoded on address bits 4:0 alone.
  - A read returns its 8-bit value on `bus_rdata[7:0]` one cycle after the read strobe, with bits 31:8 zero.
  - An offset with no readable register reads as zero. This includes 0x00, 0x08, 0x09 and 0x0C.
  - `bus_rdata` is zero in any cycle that does not follow a read strobe.
- R3: A read of offset 0x04 returns the `bus_cpu` value of that access. A read of offset 0x0A returns the parameter `NUM_CPU`.
- R4: A write to offset 0x00 sets `halt_req`, which stays high until reset. The same write loads `halt_code` with `bus_wdata[7:0]`. Every later halt write reloads the code.
- R5: A write to offset 0x08 takes `bus_wdata[7:0]` as the port number. Port N drives interrupt line N.
  - The level is 1 when the size code is 1 (two bytes) or 2 (four bytes) and `bus_wdata[15:8]` is nonzero. Otherwise the level is 0. A size code of 0 (one byte) always gives level 0.
  - A line keeps its level until it is written again.
- R6: An interrupt write whose port number is `NUM_CPU` or above leaves every interrupt line unchanged.
- R7: A read of offset 0x14 samples the receiver.
  - `rx_ready` is high in that read cycle only if `rx_valid` is high. It is never high in any other cycle.
  - If a byte is waiting, it becomes the receive data and the receive status becomes 1. If no byte is waiting, both become 0.
  - The read returns the new status.
- R8: A write to offset 0x18 does three things:
  - it stores `bus_wdata[7:0]` as the transmit data, which reads back at 0x18;
  - it sets the transmit status to 1;
  - it raises `tx_valid` for exactly the next cycle, with `tx_data` equal to that byte.
- R9: Writes to offsets 0x10, 0x14 and 0x1A overwrite the stored receive data, receive status or transmit status with `bus_wdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Access address; bits 4:0 decoded |
| bus_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| bus_size | input | 2 | Access size: 0 one byte, 1 two bytes, 2 four bytes |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_cpu | input | CPU_ID_W | Number of the requesting processor |
| bus_rdata | output | 32 | Registered read data |
| halt_req | output | 1 | Sticky halt request |
| halt_code | output | 8 | Exit code of the latest halt write |
| irq_lines | output | NUM_CPU | Level-sensitive interrupt line per processor |
| rx_data | input | 8 | Console receive byte |
| rx_valid | input | 1 | Receive byte waiting |
| rx_ready | output | 1 | Receive byte taken (during a status read) |
| tx_data | output | 8 | Console transmit byte |
| tx_valid | output | 1 | One-cycle transmit pulse |

## Verification
The assertions assume that read and write strobes are never high together, and that the strobes stay low while reset is asserted. The bench drives each access as a single strobe cycle followed by an idle cycle, so it never overlaps a read with a write. Stimulus comes from a seeded random generator that varies offsets, address bits above bit 4, size codes, data bytes, port numbers on both sides of `NUM_CPU`, and the receiver's valid state before every access. Directed cases cover the halt code, byte-wide interrupt writes and address aliasing.

// File: rtl/fwglue_pkg.sv
package fwglue_pkg;

    localparam int BUS_W  = 32;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 5;

    localparam logic [OFS_W-1:0] OFS_HALT  = 5'h00;
    localparam logic [OFS_W-1:0] OFS_CPUID = 5'h04;
    localparam logic [OFS_W-1:0] OFS_IRQ   = 5'h08;
    localparam logic [OFS_W-1:0] OFS_NCPU  = 5'h0A;
    localparam logic [OFS_W-1:0] OFS_RXDAT = 5'h10;
    localparam logic [OFS_W-1:0] OFS_RXSTS = 5'h14;
    localparam logic [OFS_W-1:0] OFS_TXDAT = 5'h18;
    localparam logic [OFS_W-1:0] OFS_TXSTS = 5'h1A;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef struct packed {
        logic halt;
        logic cpuid;
        logic irq;
        logic ncpu;
        logic rxdat;
        logic rxsts;
        logic txdat;
        logic txsts;
    } sel_t;

    typedef struct packed {
        logic [BYTE_W-1:0] dat;
        logic [BYTE_W-1:0] sts;
    } chan_t;

    function automatic sel_t decode_ofs(input logic [OFS_W-1:0] ofs);
        sel_t s;
        s       = '0;
        s.halt  = (ofs == OFS_HALT);
        s.cpuid = (ofs == OFS_CPUID);
        s.irq   = (ofs == OFS_IRQ);
        s.ncpu  = (ofs == OFS_NCPU);
        s.rxdat = (ofs == OFS_RXDAT);
        s.rxsts = (ofs == OFS_RXSTS);
        s.txdat = (ofs == OFS_TXDAT);
        s.txsts = (ofs == OFS_TXSTS);
        return s;
    endfunction

    // The level byte only exists in accesses of two or more bytes.
    function automatic logic irq_level(input logic [1:0] size,
                                       input logic [BYTE_W-1:0] lvl_byte);
        return (size != SZ_BYTE) && (lvl_byte != '0);
    endfunction

endpackage

// File: rtl/fwglue_decode.sv
module fwglue_decode
    import fwglue_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output sel_t              rd_sel,
    output sel_t              wr_sel
);
    localparam int HI_W = ADDR_W - OFS_W;

    sel_t any_sel;
    logic unused_hi;

    assign unused_hi = ^addr[ADDR_W-1 -: HI_W];
    assign any_sel   = decode_ofs(addr[OFS_W-1:0]);
    assign rd_sel    = rd ? any_sel : '0;
    assign wr_sel    = wr ? any_sel : '0;
endmodule

// File: rtl/fwglue_console.sv
module fwglue_console
    import fwglue_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_sts,
    input  logic              wr_rxdat,
    input  logic              wr_rxsts,
    input  logic              wr_txdat,
    input  logic              wr_txsts,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    output chan_t             rx_q,
    output chan_t             tx_q
);
    assign rx_ready = rd_sts & rx_valid;
    assign tx_data  = tx_q.dat;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q     <= '0;
            tx_q.dat <= '0;
            tx_q.sts <= BYTE_W'(1);
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            if (rd_sts) begin
                rx_q.dat <= rx_valid ? rx_data : '0;
                rx_q.sts <= BYTE_W'(rx_valid);
            end else begin
                if (wr_rxdat) rx_q.dat <= wbyte;
                if (wr_rxsts) rx_q.sts <= wbyte;
            end
            if (wr_txdat) begin
                tx_q.dat <= wbyte;
                tx_q.sts <= BYTE_W'(1);
                tx_valid <= 1'b1;
            end else if (wr_txsts) begin
                tx_q.sts <= wbyte;
            end
        end
    end
endmodule

// File: rtl/fwglue_irq.sv
module fwglue_irq
    import fwglue_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_irq,
    input  logic [BYTE_W-1:0]  port,
    input  logic               level,
    output logic [NUM_CPU-1:0] lines
);
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                lines[i] <= 1'b0;
            else if (wr_irq && port == BYTE_W'(i))
                lines[i] <= level;
        end
    end
endmodule

// File: rtl/fwglue_regs.sv
module fwglue_regs
    import fwglue_pkg::*;
#(
    parameter int NUM_CPU  = 4,
    parameter int ADDR_W   = 32,
    parameter int CPU_ID_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    input  logic [1:0]          bus_size,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [CPU_ID_W-1:0] bus_cpu,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                halt_req,
    output logic [BYTE_W-1:0]   halt_code,
    output logic [NUM_CPU-1:0]  irq_lines,
    input  logic [BYTE_W-1:0]   rx_data,
    input  logic                rx_valid,
    output logic                rx_ready,
    output logic [BYTE_W-1:0]   tx_data,
    output logic                tx_valid
);
    localparam int PAD_W = BUS_W - BYTE_W;
    localparam int WHI_W = BUS_W - 2 * BYTE_W;

    sel_t              rd_sel, wr_sel;
    chan_t             rx_q, tx_q;
    logic [BYTE_W-1:0] byte0, byte1, rd_byte;
    logic              unused_whi;

    assign byte0      = bus_wdata[BYTE_W-1:0];
    assign byte1      = bus_wdata[2*BYTE_W-1:BYTE_W];
    assign unused_whi = ^bus_wdata[BUS_W-1 -: WHI_W];

    fwglue_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    fwglue_console u_con (
        .clk      (clk),
        .rst      (rst),
        .rd_sts   (rd_sel.rxsts),
        .wr_rxdat (wr_sel.rxdat),
        .wr_rxsts (wr_sel.rxsts),
        .wr_txdat (wr_sel.txdat),
        .wr_txsts (wr_sel.txsts),
        .wbyte    (byte0),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .rx_q     (rx_q),
        .tx_q     (tx_q)
    );

    fwglue_irq #(.NUM_CPU(NUM_CPU)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .wr_irq (wr_sel.irq),
        .port   (byte0),
        .level  (irq_level(bus_size, byte1)),
        .lines  (irq_lines)
    );

    // Halt request is sticky; the code follows the latest halt write.
    always_ff @(posedge clk) begin
        if (rst) begin
            halt_req  <= 1'b0;
            halt_code <= '0;
        end else if (wr_sel.halt) begin
            halt_req  <= 1'b1;
            halt_code <= byte0;
        end
    end

    // Read byte mux; a status read returns the freshly sampled status.
    always_comb begin
        rd_byte = '0;
        if (rd_sel.cpuid) rd_byte = BYTE_W'(bus_cpu);
        if (rd_sel.ncpu)  rd_byte = BYTE_W'(NUM_CPU);
        if (rd_sel.rxdat) rd_byte = rx_q.dat;
        if (rd_sel.rxsts) rd_byte = BYTE_W'(rx_valid);
        if (rd_sel.txdat) rd_byte = tx_q.dat;
        if (rd_sel.txsts) rd_byte = tx_q.sts;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else
            bus_rdata <= bus_rd ? {{PAD_W{1'b0}}, rd_byte} : '0;
    end
endmodule

// File: rtl/fwglue_regs_chk.sv
module fwglue_regs_chk
    import fwglue_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [BUS_W-1:0]   bus_wdata,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [BUS_W-1:0]   bus_rdata,
    input logic               halt_req,
    input logic [BYTE_W-1:0]  halt_code,
    input logic [NUM_CPU-1:0] irq_lines,
    input logic               rx_ready,
    input logic               tx_valid
);
    // R2
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> bus_rdata == '0);

    // R2
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_W-1:BYTE_W] == '0);

    // R4
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(halt_req) |-> halt_req);

    // R4
    halt_code_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_req) |-> halt_code == $past(bus_wdata[BYTE_W-1:0]));

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr) |-> $stable(irq_lines));

    // R7
    rx_ready_status_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ready |=> bus_rdata == BUS_W'(1));

    // R8
    tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bus_wr));
endmodule

bind fwglue_regs fwglue_regs_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .halt_req  (halt_req),
    .halt_code (halt_code),
    .irq_lines (irq_lines),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid)
);

// File: tb/fwglue_regs_tb.sv
module fwglue_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_cpu = '0;
    logic [31:0] bus_rdata;
    logic        halt_req;
    logic [7:0]  halt_code;
    logic [NCPU-1:0] irq_lines;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwglue_regs #(.NUM_CPU(NCPU)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
        .bus_rdata(bus_rdata), .halt_req(halt_req), .halt_code(halt_code),
        .irq_lines(irq_lines), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_rxdat, m_rxsts, m_txdat, m_txsts, m_code;
    logic       m_halt, m_txv;
    logic [NCPU-1:0] m_irq;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [4:0] o, input logic [2:0] cpu);
        case (o)
            5'h04:   return 8'(cpu);
            5'h0A:   return 8'(NCPU);
            5'h10:   return m_rxdat;
            5'h14:   return m_rxsts;
            5'h18:   return m_txdat;
            5'h1A:   return m_txsts;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [4:0] o, input logic [1:0] sz, input logic [31:0] d);
        m_txv = 1'b0;
        case (o)
            5'h00: begin m_halt = 1'b1; m_code = d[7:0]; end
            5'h08: if (d[7:0] < 8'(NCPU))
                       m_irq[d[7:0]] = (sz != 2'd0) && (d[15:8] != 8'h00);
            5'h10: m_rxdat = d[7:0];
            5'h14: m_rxsts = d[7:0];
            5'h18: begin m_txdat = d[7:0]; m_txsts = 8'h01; m_txv = 1'b1; end
            5'h1A: m_txsts = d[7:0];
            default: ;
        endcase
    endtask

    task automatic do_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        bus_cpu = 3'($urandom_range(0, NCPU-1));
        model_write(a[4:0], sz, d);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R8 tx_valid", 32'(tx_valid), 32'(m_txv));
        if (m_txv) check("R8 tx_data", 32'(tx_data), 32'(m_txdat));
        check("R5/R6 irq_lines", 32'(irq_lines), 32'(m_irq));
        check("R4 halt_req", 32'(halt_req), 32'(m_halt));
        if (m_halt) check("R4 halt_code", 32'(halt_code), 32'(m_code));
    endtask

    task automatic do_read(input logic [31:0] a, input logic [2:0] cpu, input string req);
        logic [7:0] exp;
        logic       rdy;
        @(negedge clk);
        bus_addr = a; bus_cpu = cpu; bus_rd = 1'b1;
        bus_size = 2'($urandom_range(0, 2));
        #1 rdy = rx_ready;
        if (a[4:0] == 5'h14) begin
            m_rxdat = rx_valid ? rx_data : 8'h00;
            m_rxsts = {7'b0, rx_valid};
            check({req, " R7 rx_ready"}, 32'(rdy), 32'(rx_valid));
            exp = m_rxsts;
        end else begin
            check({req, " R7 rx_ready idle"}, 32'(rdy), 32'd0);
            exp = exp_read(a[4:0], cpu);
        end
        @(negedge clk);
        bus_rd = 1'b0;
        check({req, " R2 read data"}, bus_rdata, {24'h0, exp});
        check("R8 tx_valid after read", 32'(tx_valid), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_rxdat = 0; m_rxsts = 0; m_txdat = 0; m_txsts = 8'h01;
        m_code = 0; m_halt = 0; m_txv = 0; m_irq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_lines", 32'(irq_lines), 32'd0);
        check("R1 halt_req", 32'(halt_req), 32'd0);
        check("R1 tx_valid", 32'(tx_valid), 32'd0);
        check("R2 idle rdata", bus_rdata, 32'd0);
        do_read(32'h18, 3'd0, "R1 tx data");
        do_read(32'h1A, 3'd0, "R1 tx status");
        do_read(32'h10, 3'd0, "R1 rx data");
        rx_valid = 1'b0;
        do_read(32'h14, 3'd0, "R1 rx status");

        // R3 and R2 aliasing / undecoded
        do_read(32'h04, 3'd2, "R3 cpu id");
        do_read(32'h0A, 3'd1, "R3 count");
        do_read(32'hABCD_0024, 3'd3, "R2 alias cpu id");
        do_read(32'h00, 3'd0, "R2 halt offset");
        do_read(32'h08, 3'd0, "R2 irq offset");
        do_read(32'h09, 3'd0, "R2 level offset");
        do_read(32'h0C, 3'd0, "R2 hole");

        // R5 half-word write drives line 2 high, byte write drives it low
        do_write(32'h08, 2'd1, 32'h0000_0102);
        check("R5 line 2 set", 32'(irq_lines), 32'h4);
        do_write(32'h08, 2'd0, 32'h0000_FF02);
        check("R5 byte write level 0", 32'(irq_lines), 32'h0);
        do_write(32'h08, 2'd2, 32'h0000_0100);
        // R6 out-of-range ports
        do_write(32'h08, 2'd1, 32'h0000_0104);
        do_write(32'h08, 2'd1, 32'h0000_01FF);
        check("R6 ignored port", 32'(irq_lines), 32'h1);

        // R7 receive sampling
        rx_valid = 1'b1; rx_data = 8'h41;
        do_read(32'h10, 3'd0, "R7 data read no sample");
        do_read(32'h14, 3'd0, "R7 status with byte");
        do_read(32'h10, 3'd0, "R7 latched byte");
        rx_valid = 1'b0;
        do_read(32'h14, 3'd0, "R7 status empty");
        do_read(32'h10, 3'd0, "R7 cleared byte");

        // R8 transmit
        do_write(32'h1A, 2'd0, 32'h0);
        do_write(32'h18, 2'd0, 32'h77);
        do_read(32'h1A, 3'd0, "R8 tx status set");
        do_read(32'h18, 3'd0, "R8 tx data readback");

        // R9 direct overwrites
        do_write(32'h10, 2'd0, 32'h99);
        do_read(32'h10, 3'd0, "R9 rx data");
        do_write(32'h14, 2'd2, 32'h1234_5605);
        do_read(32'h14 | 32'h20, 3'd0, "R9 rx status via sample");
        do_write(32'h1A, 2'd0, 32'h3C);
        do_read(32'h1A, 3'd0, "R9 tx status");

        // R4 halt
        do_write(32'h00, 2'd2, 32'h0000_005A);
        do_write(32'h00, 2'd0, 32'h0000_0033);

        // constrained random mix
        for (int i = 0; i < 800; i++) begin
            logic [4:0]  o;
            logic [31:0] a, d;
            logic [1:0]  sz;
            case ($urandom_range(0, 9))
                0: o = 5'h00; 1: o = 5'h04; 2: o = 5'h08; 3: o = 5'h09;
                4: o = 5'h0A; 5: o = 5'h10; 6: o = 5'h14; 7: o = 5'h18;
                8: o = 5'h1A; default: o = 5'($urandom);
            endcase
            a  = {$urandom, o} >> 0;
            a[4:0] = o;
            sz = 2'($urandom_range(0, 2));
            d  = $urandom;
            if (o == 5'h08) d[7:0] = 8'($urandom_range(0, 2*NCPU));
            rx_valid = 1'($urandom);
            rx_data  = 8'($urandom);
            if ($urandom_range(0, 1) == 0)
                do_write(a, sz, d);
            else
                do_read(a, 3'($urandom_range(0, NCPU-1)), "random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule